// File: doc/BRIEF.md
# Clock Failure Fallback Controller

This block owns the system clock configuration of a chip: which source drives the system clock (internal RC oscillator, external crystal oscillator or main PLL), where the main PLL takes its reference, and the enables of the external oscillator, the main PLL and the audio PLL. Software loads a new configuration through a single-cycle write strobe. A clock monitor outside the block raises a one-cycle pulse when it sees the external oscillator stop.

When such a pulse arrives while monitoring is switched on, the block looks at the configuration currently in force. If the external oscillator drives the system clock, either directly or as the reference of the PLL that is selected, the block moves the system clock back to the internal RC oscillator. It also drops the enables of everything that depended on the failed oscillator. In every accepted case it sets a sticky failure flag. The interrupt output mirrors that flag. Software acknowledges the flag with a write-one-to-clear pulse. The analog oscillators, the glitch-free clock switch and the detector are outside this block; they are seen only as control bits.

Top module: `clk_fail_fallback`

## Requirements
- R1: After synchronous reset the select reads 0 (internal RC), the PLL reference bit reads 0 (internal RC), all three enables read 0, and the flag and interrupt read 0.
- R2: A write strobe with no accepted failure in the same cycle loads the select, PLL reference and three enables, visible one cycle after the strobe. Select codes are 0 = internal RC, 1 = external oscillator, 2 = PLL. A PLL reference of 1 means the external oscillator.
- R3: An accepted failure while the select is 1 gives select 0 and external oscillator enable 0 one cycle later. The PLL reference and the two PLL enables keep their values.
- R4: An accepted failure while the select is 2 and the PLL reference is 1 gives select 0, and clears the external oscillator enable, the main PLL enable and the audio PLL enable, one cycle later. The PLL reference keeps its value.
- R5: An accepted failure while the external oscillator drives neither the system clock nor the selected PLL leaves the select, the PLL reference and all enables unchanged. It still sets the flag.
- R6: A failure pulse while the monitor enable is 0 changes no output.
- R7: The flag is set one cycle after an accepted failure. It stays set until a clear pulse. When a set and a clear happen in the same cycle, the set wins.
- R8: The interrupt output equals the flag in every cycle.
- R9: When a failure is accepted in the same cycle as a write strobe, the write is discarded. The fallback is judged on the configuration that was in force before that cycle.
- R10: A write with the reserved select code 3 keeps the previous select. The other written fields still load.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| mon_en | input | 1 | Monitoring enable; failures are ignored when low |
| fail_pulse | input | 1 | One-cycle failure indication from the clock monitor |
| cfg_wr | input | 1 | Configuration write strobe |
| wr_sysclk_sel | input | 2 | Written system clock select (0 RC, 1 ext osc, 2 PLL, 3 reserved) |
| wr_pll_ref_xo | input | 1 | Written PLL reference (1 = external oscillator) |
| wr_xo_en | input | 1 | Written external oscillator enable |
| wr_pll_en | input | 1 | Written main PLL enable |
| wr_apll_en | input | 1 | Written audio PLL enable |
| flag_clr | input | 1 | Write-one-to-clear pulse for the failure flag |
| sysclk_sel | output | 2 | System clock select in force |
| pll_ref_xo | output | 1 | PLL reference in force |
| xo_en | output | 1 | External oscillator enable |
| pll_en | output | 1 | Main PLL enable |
| apll_en | output | 1 | Audio PLL enable |
| fail_flag | output | 1 | Sticky failure flag |
| fail_irq | output | 1 | Failure interrupt |

## Verification
The hardest situation to reach is the indirect one: a failure that strikes while the PLL, fed from the external oscillator, is the system clock. Here the teardown must also reach the audio PLL. The stimulus first loads that exact configuration through a write, checks that it took hold, and only then pulses the failure input. The same sequence is run with the audio PLL enable on and off, and with the PLL fed from the RC oscillator, so that the teardown is seen to follow the reference bit. A failure that arrives together with a write is driven separately. This shows that the fallback is judged on the old configuration.

// File: rtl/clkfb_pkg.sv
package clkfb_pkg;

    localparam int SEL_W = 2;

    typedef enum logic [SEL_W-1:0] {
        SEL_RC  = 2'd0,
        SEL_XO  = 2'd1,
        SEL_PLL = 2'd2,
        SEL_RSV = 2'd3
    } sysclk_e;

    typedef struct packed {
        sysclk_e sel;
        logic    pll_xo;
        logic    xo_en;
        logic    pll_en;
        logic    apll_en;
    } clk_cfg_t;

    typedef enum logic [1:0] {
        HIT_NONE   = 2'd0,
        HIT_DIRECT = 2'd1,
        HIT_PLL    = 2'd2
    } hit_e;

    localparam clk_cfg_t CFG_RST = '{
        sel: SEL_RC, pll_xo: 1'b0, xo_en: 1'b0, pll_en: 1'b0, apll_en: 1'b0
    };

    // Which path, if any, depends on the external oscillator.
    function automatic hit_e classify(input clk_cfg_t c);
        hit_e h;
        case (c.sel)
            SEL_XO:  h = HIT_DIRECT;
            SEL_PLL: h = c.pll_xo ? HIT_PLL : HIT_NONE;
            default: h = HIT_NONE;
        endcase
        return h;
    endfunction

    // Configuration after a fallback of the given kind.
    function automatic clk_cfg_t fallback(input clk_cfg_t c, input hit_e h);
        clk_cfg_t n;
        n = c;
        case (h)
            HIT_DIRECT: begin
                n.sel   = SEL_RC;
                n.xo_en = 1'b0;
            end
            HIT_PLL: begin
                n.sel     = SEL_RC;
                n.xo_en   = 1'b0;
                n.pll_en  = 1'b0;
                n.apll_en = 1'b0;
            end
            default: n = c;
        endcase
        return n;
    endfunction

endpackage

// File: rtl/clkfb_hit_eval.sv
module clkfb_hit_eval
    import clkfb_pkg::*;
(
    input  clk_cfg_t cur_cfg,
    input  logic     mon_en,
    input  logic     fail_pulse,
    output logic     accept,
    output hit_e     hit
);
    always_comb begin
        accept = mon_en & fail_pulse;
        hit    = accept ? classify(cur_cfg) : HIT_NONE;
    end
endmodule

// File: rtl/clkfb_cfg_reg.sv
module clkfb_cfg_reg
    import clkfb_pkg::*;
(
    input  logic     clk,
    input  logic     rst,
    input  logic     wr,
    input  clk_cfg_t wr_cfg,
    input  logic     accept,
    input  hit_e     hit,
    output clk_cfg_t cfg
);
    clk_cfg_t nxt;

    always_comb begin
        nxt = cfg;
        if (accept) begin
            nxt = fallback(cfg, hit);
        end else if (wr) begin
            nxt = wr_cfg;
            if (wr_cfg.sel == SEL_RSV) begin
                nxt.sel = cfg.sel;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) cfg <= CFG_RST;
        else     cfg <= nxt;
    end
endmodule

// File: rtl/clkfb_flag.sv
module clkfb_flag (
    input  logic clk,
    input  logic rst,
    input  logic set_i,
    input  logic clr_i,
    output logic flag
);
    always_ff @(posedge clk) begin
        if (rst)        flag <= 1'b0;
        else if (set_i) flag <= 1'b1;
        else if (clr_i) flag <= 1'b0;
    end
endmodule

// File: rtl/clk_fail_fallback.sv
module clk_fail_fallback
    import clkfb_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             mon_en,
    input  logic             fail_pulse,
    input  logic             cfg_wr,
    input  logic [SEL_W-1:0] wr_sysclk_sel,
    input  logic             wr_pll_ref_xo,
    input  logic             wr_xo_en,
    input  logic             wr_pll_en,
    input  logic             wr_apll_en,
    input  logic             flag_clr,
    output logic [SEL_W-1:0] sysclk_sel,
    output logic             pll_ref_xo,
    output logic             xo_en,
    output logic             pll_en,
    output logic             apll_en,
    output logic             fail_flag,
    output logic             fail_irq
);
    clk_cfg_t cfg_q;
    clk_cfg_t wr_cfg;
    logic     accept;
    hit_e     hit;

    always_comb begin
        wr_cfg.sel     = sysclk_e'(wr_sysclk_sel);
        wr_cfg.pll_xo  = wr_pll_ref_xo;
        wr_cfg.xo_en   = wr_xo_en;
        wr_cfg.pll_en  = wr_pll_en;
        wr_cfg.apll_en = wr_apll_en;
    end

    clkfb_hit_eval u_eval (
        .cur_cfg    (cfg_q),
        .mon_en     (mon_en),
        .fail_pulse (fail_pulse),
        .accept     (accept),
        .hit        (hit)
    );

    clkfb_cfg_reg u_cfg (
        .clk    (clk),
        .rst    (rst),
        .wr     (cfg_wr),
        .wr_cfg (wr_cfg),
        .accept (accept),
        .hit    (hit),
        .cfg    (cfg_q)
    );

    clkfb_flag u_flag (
        .clk   (clk),
        .rst   (rst),
        .set_i (accept),
        .clr_i (flag_clr),
        .flag  (fail_flag)
    );

    assign sysclk_sel = cfg_q.sel;
    assign pll_ref_xo = cfg_q.pll_xo;
    assign xo_en      = cfg_q.xo_en;
    assign pll_en     = cfg_q.pll_en;
    assign apll_en    = cfg_q.apll_en;
    assign fail_irq   = fail_flag;
endmodule

// File: rtl/clk_fail_fallback_chk.sv
module clk_fail_fallback_chk (
    input logic       clk,
    input logic       rst,
    input logic       mon_en,
    input logic       fail_pulse,
    input logic       cfg_wr,
    input logic [1:0] wr_sysclk_sel,
    input logic       flag_clr,
    input logic [1:0] sysclk_sel,
    input logic       pll_ref_xo,
    input logic       xo_en,
    input logic       pll_en,
    input logic       apll_en,
    input logic       fail_flag,
    input logic       fail_irq
);
    // R3
    direct_fallback_chk: assert property (@(posedge clk) disable iff (rst)
        (mon_en && fail_pulse && sysclk_sel == 2'd1)
        |=> (sysclk_sel == 2'd0 && !xo_en && $stable(pll_en) && $stable(apll_en)));

    // R4
    pll_teardown_chk: assert property (@(posedge clk) disable iff (rst)
        (mon_en && fail_pulse && sysclk_sel == 2'd2 && pll_ref_xo)
        |=> (sysclk_sel == 2'd0 && !xo_en && !pll_en && !apll_en && $stable(pll_ref_xo)));

    // R5
    unaffected_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (mon_en && fail_pulse && (sysclk_sel == 2'd0 || (sysclk_sel == 2'd2 && !pll_ref_xo)))
        |=> ($stable(sysclk_sel) && $stable(xo_en) && $stable(pll_en) && $stable(apll_en)));

    // R6
    mon_off_ignore_chk: assert property (@(posedge clk) disable iff (rst)
        (!mon_en && fail_pulse && !cfg_wr && !flag_clr)
        |=> ($stable(sysclk_sel) && $stable(xo_en) && $stable(pll_en) && $stable(fail_flag)));

    // R7
    flag_set_chk: assert property (@(posedge clk) disable iff (rst)
        (mon_en && fail_pulse) |=> fail_flag);

    // R7
    flag_sticky_chk: assert property (@(posedge clk) disable iff (rst)
        (fail_flag && !flag_clr) |=> fail_flag);

    // R9
    write_dropped_chk: assert property (@(posedge clk) disable iff (rst)
        (mon_en && fail_pulse && cfg_wr && sysclk_sel == 2'd0)
        |=> ($stable(sysclk_sel) && $stable(pll_ref_xo) && $stable(xo_en) && $stable(pll_en)));

    // R10
    reserved_sel_chk: assert property (@(posedge clk) disable iff (rst)
        (cfg_wr && wr_sysclk_sel == 2'd3 && !(mon_en && fail_pulse)) |=> $stable(sysclk_sel));

    // R8
    always_comb begin
        if (!rst) irq_mirror_chk: assert (fail_irq == fail_flag);
    end
endmodule

bind clk_fail_fallback clk_fail_fallback_chk chk_i (
    .clk           (clk),
    .rst           (rst),
    .mon_en        (mon_en),
    .fail_pulse    (fail_pulse),
    .cfg_wr        (cfg_wr),
    .wr_sysclk_sel (wr_sysclk_sel),
    .flag_clr      (flag_clr),
    .sysclk_sel    (sysclk_sel),
    .pll_ref_xo    (pll_ref_xo),
    .xo_en         (xo_en),
    .pll_en        (pll_en),
    .apll_en       (apll_en),
    .fail_flag     (fail_flag),
    .fail_irq      (fail_irq)
);

// File: tb/clk_fail_fallback_tb_top.sv
module clk_fail_fallback_tb_top;
    localparam int CLK_PERIOD = 10;
    localparam int WATCHDOG   = 5000;

    logic       clk = 1'b0;
    logic       rst;
    logic       mon_en, fail_pulse, cfg_wr, flag_clr;
    logic [1:0] wr_sysclk_sel;
    logic       wr_pll_ref_xo, wr_xo_en, wr_pll_en, wr_apll_en;
    logic [1:0] sysclk_sel;
    logic       pll_ref_xo, xo_en, pll_en, apll_en, fail_flag, fail_irq;

    int n_checks = 0;
    int n_errors = 0;
    bit done = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    clk_fail_fallback dut_i (
        .clk(clk), .rst(rst), .mon_en(mon_en), .fail_pulse(fail_pulse),
        .cfg_wr(cfg_wr), .wr_sysclk_sel(wr_sysclk_sel), .wr_pll_ref_xo(wr_pll_ref_xo),
        .wr_xo_en(wr_xo_en), .wr_pll_en(wr_pll_en), .wr_apll_en(wr_apll_en),
        .flag_clr(flag_clr), .sysclk_sel(sysclk_sel), .pll_ref_xo(pll_ref_xo),
        .xo_en(xo_en), .pll_en(pll_en), .apll_en(apll_en),
        .fail_flag(fail_flag), .fail_irq(fail_irq)
    );

    // Packed observation: {sel[1:0], ref, xo, pll, apll, flag}
    function automatic logic [6:0] obs();
        return {sysclk_sel, pll_ref_xo, xo_en, pll_en, apll_en, fail_flag};
    endfunction

    task automatic check(input string req, input logic [6:0] exp);
        n_checks++;
        if (obs() !== exp || fail_irq !== fail_flag) begin
            n_errors++;
            $display("FAIL %s: got sel=%0d ref=%0b xo=%0b pll=%0b apll=%0b flag=%0b irq=%0b, expected %b",
                     req, sysclk_sel, pll_ref_xo, xo_en, pll_en, apll_en, fail_flag, fail_irq, exp);
        end
    endtask

    task automatic idle();
        mon_en = 1'b1; fail_pulse = 1'b0; cfg_wr = 1'b0; flag_clr = 1'b0;
    endtask

    // Drive at a falling edge, let one rising edge pass, return at the next falling edge.
    task automatic cycle();
        @(negedge clk);
    endtask

    task automatic write_cfg(input logic [1:0] s, input logic r, input logic x,
                             input logic p, input logic a);
        cfg_wr = 1'b1; wr_sysclk_sel = s; wr_pll_ref_xo = r;
        wr_xo_en = x; wr_pll_en = p; wr_apll_en = a;
        cycle();
        cfg_wr = 1'b0;
    endtask

    task automatic clear_flag();
        flag_clr = 1'b1;
        cycle();
        flag_clr = 1'b0;
    endtask

    typedef struct packed {
        logic [1:0] sel;
        logic       rf;
        logic       xo;
        logic       pll;
        logic       apll;
        logic       mon;
        logic [6:0] exp;
    } vec_t;

    localparam int NV = 7;
    localparam vec_t VECS [NV] = '{
        // R3: ext osc direct
        '{2'd1, 1'b0, 1'b1, 1'b1, 1'b1, 1'b1, 7'b00_0_0_1_1_1},
        // R4: PLL fed from ext osc, audio PLL on
        '{2'd2, 1'b1, 1'b1, 1'b1, 1'b1, 1'b1, 7'b00_1_0_0_0_1},
        // R4: PLL fed from ext osc, audio PLL off
        '{2'd2, 1'b1, 1'b1, 1'b1, 1'b0, 1'b1, 7'b00_1_0_0_0_1},
        // R5: PLL fed from RC
        '{2'd2, 1'b0, 1'b1, 1'b1, 1'b1, 1'b1, 7'b10_0_1_1_1_1},
        // R5: RC selected
        '{2'd0, 1'b1, 1'b1, 1'b1, 1'b1, 1'b1, 7'b00_1_1_1_1_1},
        // R6: monitor off, direct case
        '{2'd1, 1'b0, 1'b1, 1'b0, 1'b1, 1'b0, 7'b01_0_1_0_1_0},
        // R6: monitor off, PLL case
        '{2'd2, 1'b1, 1'b1, 1'b1, 1'b1, 1'b0, 7'b10_1_1_1_1_0}
    };

    initial begin
        repeat (WATCHDOG) @(posedge clk);
        if (!done) begin
            n_errors++;
            n_checks++;
            $display("FAIL watchdog: got timeout, expected completion");
            $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
            $finish;
        end
    end

    initial begin
        idle();
        wr_sysclk_sel = 2'd0; wr_pll_ref_xo = 1'b0;
        wr_xo_en = 1'b0; wr_pll_en = 1'b0; wr_apll_en = 1'b0;
        rst = 1'b1;
        repeat (3) cycle();
        rst = 1'b0;
        cycle();
        // R1
        check("R1 reset", 7'b00_0_0_0_0_0);

        for (int i = 0; i < NV; i++) begin
            idle();
            clear_flag();
            write_cfg(VECS[i].sel, VECS[i].rf, VECS[i].xo, VECS[i].pll, VECS[i].apll);
            // R2
            check("R2 load", {VECS[i].sel, VECS[i].rf, VECS[i].xo, VECS[i].pll, VECS[i].apll, 1'b0});
            mon_en = VECS[i].mon; fail_pulse = 1'b1;
            cycle();
            fail_pulse = 1'b0;
            check("R3/R4/R5/R6 vector", VECS[i].exp);
        end

        // R7 sticky flag, clear, and set winning over clear
        idle();
        clear_flag();
        write_cfg(2'd0, 1'b0, 1'b1, 1'b0, 1'b0);
        fail_pulse = 1'b1;
        cycle();
        fail_pulse = 1'b0;
        repeat (4) cycle();
        check("R7 sticky", 7'b00_0_1_0_0_1);
        clear_flag();
        check("R7 clear", 7'b00_0_1_0_0_0);
        fail_pulse = 1'b1; flag_clr = 1'b1;
        cycle();
        idle();
        check("R7 set wins", 7'b00_0_1_0_0_1);
        clear_flag();
        // R8: irq checked in every check; explicit low-state check
        check("R8 irq low", 7'b00_0_1_0_0_0);

        // R9: failure with write in same cycle, old config is ext osc direct
        write_cfg(2'd1, 1'b0, 1'b1, 1'b1, 1'b0);
        cfg_wr = 1'b1; wr_sysclk_sel = 2'd2; wr_pll_ref_xo = 1'b1;
        wr_xo_en = 1'b1; wr_pll_en = 1'b1; wr_apll_en = 1'b1;
        fail_pulse = 1'b1;
        cycle();
        idle();
        check("R9 write dropped", 7'b00_0_0_1_0_1);
        clear_flag();

        // R10: reserved select keeps previous select, other fields load
        write_cfg(2'd2, 1'b0, 1'b0, 1'b1, 1'b0);
        write_cfg(2'd3, 1'b1, 1'b1, 1'b0, 1'b1);
        check("R10 reserved sel", 7'b10_1_1_0_1_0);

        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
        $finish;
    end
endmodule